// File: doc/BRIEF.md
# Converter Operation Sequencer

This controller runs whole operations on a 24-bit sigma-delta converter by issuing a series of register transactions to a lower-level register access engine. It accepts one command at a time. A command is a single conversion on a chosen channel, a two-pass internal calibration, or an interface reset with a presence check. When the operation finishes, the block returns one response: a 32-bit value and a 2-bit completion code.

For conversions and calibrations, the block first builds the configuration word and writes it. The caller's opaque bits go into that word, with the gain, channel, coding and buffering fields placed over them. The block then writes a mode word, and after that it keeps reading the status byte until the converter reports a result. Polling stops early in two cases: a poll limit is reached, or the status error flag is raised. For a reset, the block asks the engine for the interface-reset pattern. It then checks the identification byte and the fixed marker bits of the status byte.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1, `req_valid` is 0 and `rsp_valid` is 0.
- R2: The configuration word puts the gain field in bits 10:8, the channel in bits 3:0 and the unipolar flag in bit 12. Every other bit comes unchanged from `cmd_cfg_misc`.
- R3: Bit 4 (buffered) of the configuration word is 1 whenever the gain field is 2 or more (gain above 2). Otherwise bit 4 is a copy of `cmd_cfg_misc[4]`.
- R4: A conversion (`cmd_op`=0) runs these transactions in order: write address 2 with the configuration word; write address 1 with bits 15:13 = 001 and bits 12:0 = `cmd_mode_misc`; read address 0 repeatedly until status bit 7 reads 0; read address 3. The response data is {8'h00, data}, with code 0.
- R5: A calibration (`cmd_op`=1) writes the configuration word, then a mode word with bits 15:13 = 100, and polls. It then writes a mode word with bits 15:13 = 101 and polls again. Success returns data 0 with code 0, and address 3 is never read.
- R6: If POLL_MAX status reads in one polling pass all show bit 7 = 1, the operation ends with data 32'hFFFFFFFF and code 0. No further transactions are issued.
- R7: If the first ready status read has bit 6 set, the operation ends with data 0 and code 2 (other error). No data is read.
- R8: A reset (`cmd_op`=2) issues one transaction with `req_rst`=1, then reads address 4. An identification byte of 8'h00 or 8'hFF ends the operation with code 1 (no device) and data = {24'h0, id}.
- R9: Otherwise the reset reads address 0. If status bits 4:3 equal 01, it returns code 0; any other value returns code 2. In both cases the data is {24'h0, id}.
- R10: While `req_valid` is 1 and `req_ack` is 0, the request fields stay unchanged in the next cycle.
- R11: `rsp_valid` is a one-cycle pulse. `cmd_ready` is 0 from the cycle after a command is accepted until that pulse.
- R12: `cmd_op`=3 is answered with code 2 and data 0, without issuing any transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 2 | 0 convert, 1 calibrate, 2 reset, 3 unused |
| cmd_chan | input | 4 | Channel field |
| cmd_gain | input | 3 | Gain exponent (gain = 1 << field) |
| cmd_unipolar | input | 1 | Unipolar coding select |
| cmd_cfg_misc | input | 16 | Opaque reference/bias bits of the configuration word |
| cmd_mode_misc | input | 13 | Opaque low bits of the mode word |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Result, identification byte or not-ready sentinel |
| rsp_code | output | 2 | 0 none, 1 no device, 2 other error |
| req_valid | output | 1 | Register request pending |
| req_rst | output | 1 | Request is the interface-reset pattern |
| req_wr | output | 1 | Request is a write |
| req_addr | output | 3 | Register address |
| req_wdata | output | 24 | Write data |
| req_ack | input | 1 | Engine completed the request |
| req_rdata | input | 24 | Read data, valid with `req_ack` |

## Verification
The bench covers all 8 gain codes and all 16 channels. It drives opaque patterns whose buffered bit is both clear and set. A wrong field mask would corrupt the reference bits, and a wrong gain threshold would either leave low-gain words buffered or fail to force the bit on gain 4. The model answers after a varying number of not-ready polls, so a design with an off-by-one in its poll limit shows up in two ways: it ends a timeout with the wrong number of reads, or it reads data before status reports ready. The error flag, both identification extremes, a bad marker and the unused opcode are each driven once. A design that read data despite an error, or treated 8'hFF as present, would return the wrong code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CFG_W    = 16;
    localparam int MMISC_W  = 13;
    localparam int DATA_W   = 24;
    localparam int RSP_W    = 32;
    localparam int ADDR_W   = 3;

    localparam logic [RSP_W-1:0] NOT_READY = 32'hFFFF_FFFF;

    // register addresses decoded by the access engine
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CONFIG = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA   = 3'd3;
    localparam logic [ADDR_W-1:0] A_IDENT  = 3'd4;

    // operation codes placed in mode bits 15:13
    localparam logic [2:0] MD_SINGLE = 3'b001;
    localparam logic [2:0] MD_ZS_CAL = 3'b100;
    localparam logic [2:0] MD_FS_CAL = 3'b101;

    typedef enum logic [1:0] {
        OP_CONVERT = 2'd0,
        OP_CALIB   = 2'd1,
        OP_RESET   = 2'd2,
        OP_NONE    = 2'd3
    } seq_op_e;

    typedef enum logic [1:0] {
        RC_NONE   = 2'd0,
        RC_NODEV  = 2'd1,
        RC_OTHER  = 2'd2
    } rsp_code_e;

    typedef enum logic [3:0] {
        S_IDLE, S_WR_CFG, S_WR_MODE, S_POLL, S_RD_DATA,
        S_IF_RST, S_RD_ID, S_RD_STAT
    } seq_state_e;

endpackage

// File: rtl/adc_cfg_pack.sv
module adc_cfg_pack
    import adc_seq_pkg::*;
#(
    parameter int GAIN_W  = 3,
    parameter int CHAN_W  = 4,
    parameter int BUF_MIN = 2
) (
    input  logic [GAIN_W-1:0] gain,
    input  logic [CHAN_W-1:0] chan,
    input  logic              unipolar,
    input  logic [CFG_W-1:0]  misc,
    output logic [CFG_W-1:0]  cfg_word
);
    localparam logic [CFG_W-1:0] OWNED = 16'h171F;

    logic force_buf;

    always_comb begin
        force_buf = (32'(gain) >= BUF_MIN);
        cfg_word  = misc & ~OWNED;
        cfg_word[12]   = unipolar;
        cfg_word[10:8] = gain;
        cfg_word[3:0]  = chan;
        cfg_word[4]    = misc[4] | force_buf;
    end
endmodule

// File: rtl/adc_stat_decode.sv
module adc_stat_decode (
    input  logic       nrdy_bit,
    input  logic       err_bit,
    input  logic [1:0] marker,
    output logic       ready,
    output logic       fault,
    output logic       marker_ok
);
    always_comb begin
        ready     = ~nrdy_bit;
        fault     = err_bit;
        marker_ok = (marker == 2'b01);
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int POLL_MAX = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_op,
    input  logic [3:0]          cmd_chan,
    input  logic [2:0]          cmd_gain,
    input  logic                cmd_unipolar,
    input  logic [CFG_W-1:0]    cmd_cfg_misc,
    input  logic [MMISC_W-1:0]  cmd_mode_misc,
    output logic                rsp_valid,
    output logic [RSP_W-1:0]    rsp_data,
    output logic [1:0]          rsp_code,
    output logic                req_valid,
    output logic                req_rst,
    output logic                req_wr,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [DATA_W-1:0]   req_wdata,
    input  logic                req_ack,
    input  logic [DATA_W-1:0]   req_rdata
);
    localparam int PW = $clog2(POLL_MAX + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);

    typedef struct packed {
        seq_state_e          st;
        seq_op_e             op;
        logic                pass;
        logic [PW-1:0]       polls;
        logic [CFG_W-1:0]    cfg;
        logic [MMISC_W-1:0]  mmisc;
        logic [7:0]          id;
        logic                rv;
        logic [RSP_W-1:0]    rdat;
        rsp_code_e           rc;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [CFG_W-1:0] cfg_new;
    logic st_ready, st_fault, st_marker_ok;
    logic [2:0] mode_code;

    adc_cfg_pack u_pack (
        .gain     (cmd_gain),
        .chan     (cmd_chan),
        .unipolar (cmd_unipolar),
        .misc     (cmd_cfg_misc),
        .cfg_word (cfg_new)
    );

    adc_stat_decode u_stat (
        .nrdy_bit  (req_rdata[7]),
        .err_bit   (req_rdata[6]),
        .marker    (req_rdata[4:3]),
        .ready     (st_ready),
        .fault     (st_fault),
        .marker_ok (st_marker_ok)
    );

    always_comb begin
        if (ctx_q.op == OP_CALIB) mode_code = ctx_q.pass ? MD_FS_CAL : MD_ZS_CAL;
        else                      mode_code = MD_SINGLE;
    end

    // request fields come from registered state only
    always_comb begin
        req_valid = (ctx_q.st != S_IDLE);
        req_rst   = (ctx_q.st == S_IF_RST);
        req_wr    = (ctx_q.st == S_WR_CFG) || (ctx_q.st == S_WR_MODE);
        req_wdata = '0;
        case (ctx_q.st)
            S_WR_CFG:  begin req_addr = A_CONFIG; req_wdata = {8'h00, ctx_q.cfg}; end
            S_WR_MODE: begin req_addr = A_MODE;   req_wdata = {8'h00, mode_code, ctx_q.mmisc}; end
            S_RD_DATA: req_addr = A_DATA;
            S_RD_ID:   req_addr = A_IDENT;
            default:   req_addr = A_STATUS;
        endcase
    end

    always_comb begin
        ctx_d    = ctx_q;
        ctx_d.rv = 1'b0;
        case (ctx_q.st)
            S_IDLE: if (cmd_valid) begin
                ctx_d.op    = seq_op_e'(cmd_op);
                ctx_d.cfg   = cfg_new;
                ctx_d.mmisc = cmd_mode_misc;
                ctx_d.pass  = 1'b0;
                ctx_d.polls = '0;
                case (seq_op_e'(cmd_op))
                    OP_RESET: ctx_d.st = S_IF_RST;
                    OP_NONE: begin
                        ctx_d.rv = 1'b1; ctx_d.rdat = '0; ctx_d.rc = RC_OTHER;
                    end
                    default:  ctx_d.st = S_WR_CFG;
                endcase
            end
            S_WR_CFG: if (req_ack) ctx_d.st = S_WR_MODE;
            S_WR_MODE: if (req_ack) begin
                ctx_d.st    = S_POLL;
                ctx_d.polls = '0;
            end
            S_POLL: if (req_ack) begin
                if (!st_ready) begin
                    if (ctx_q.polls == POLL_LAST) begin
                        ctx_d.st = S_IDLE; ctx_d.rv = 1'b1;
                        ctx_d.rdat = NOT_READY; ctx_d.rc = RC_NONE;
                    end else begin
                        ctx_d.polls = ctx_q.polls + 1'b1;
                    end
                end else if (st_fault) begin
                    ctx_d.st = S_IDLE; ctx_d.rv = 1'b1;
                    ctx_d.rdat = '0; ctx_d.rc = RC_OTHER;
                end else if (ctx_q.op == OP_CONVERT) begin
                    ctx_d.st = S_RD_DATA;
                end else if (!ctx_q.pass) begin
                    ctx_d.pass = 1'b1;
                    ctx_d.st   = S_WR_MODE;
                end else begin
                    ctx_d.st = S_IDLE; ctx_d.rv = 1'b1;
                    ctx_d.rdat = '0; ctx_d.rc = RC_NONE;
                end
            end
            S_RD_DATA: if (req_ack) begin
                ctx_d.st = S_IDLE; ctx_d.rv = 1'b1;
                ctx_d.rdat = {8'h00, req_rdata}; ctx_d.rc = RC_NONE;
            end
            S_IF_RST: if (req_ack) ctx_d.st = S_RD_ID;
            S_RD_ID: if (req_ack) begin
                ctx_d.id = req_rdata[7:0];
                if (req_rdata[7:0] == 8'h00 || req_rdata[7:0] == 8'hFF) begin
                    ctx_d.st = S_IDLE; ctx_d.rv = 1'b1;
                    ctx_d.rdat = {24'h0, req_rdata[7:0]}; ctx_d.rc = RC_NODEV;
                end else begin
                    ctx_d.st = S_RD_STAT;
                end
            end
            S_RD_STAT: if (req_ack) begin
                ctx_d.st = S_IDLE; ctx_d.rv = 1'b1;
                ctx_d.rdat = {24'h0, ctx_q.id};
                ctx_d.rc = st_marker_ok ? RC_NONE : RC_OTHER;
            end
            default: ctx_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: S_IDLE, op: OP_CONVERT, rc: RC_NONE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign cmd_ready = (ctx_q.st == S_IDLE);
    assign rsp_valid = ctx_q.rv;
    assign rsp_data  = ctx_q.rdat;
    assign rsp_code  = ctx_q.rc;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic        req_valid,
    input logic        req_rst,
    input logic        req_wr,
    input logic [2:0]  req_addr,
    input logic [23:0] req_wdata,
    input logic        req_ack
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_addr)
            && $stable(req_wdata) && $stable(req_wr) && $stable(req_rst)));

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!cmd_ready || rsp_valid));

    // R3
    buf_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_wr && req_addr == 3'd2 && req_wdata[10:9] != 2'b00)
            |-> req_wdata[4]);

    // R4
    mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_wr && req_addr == 3'd1)
            |-> (req_wdata[15:13] == 3'b001 || req_wdata[15:13] == 3'b100
                 || req_wdata[15:13] == 3'b101));

    // R6
    rsp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data == 32'hFFFF_FFFF || rsp_data[31:24] == 8'h00));

    // R8
    rst_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_rst |-> !req_wr);
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .req_valid (req_valid),
    .req_rst   (req_rst),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ack   (req_ack)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    localparam int POLLS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [3:0]  cmd_chan = '0;
    logic [2:0]  cmd_gain = '0;
    logic        cmd_unipolar = 1'b0;
    logic [15:0] cmd_cfg_misc = '0;
    logic [12:0] cmd_mode_misc = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [1:0]  rsp_code;
    logic        req_valid, req_rst, req_wr;
    logic [2:0]  req_addr;
    logic [23:0] req_wdata;
    logic        req_ack = 1'b0;
    logic [23:0] req_rdata = '0;

    adc_seq_ctrl #(.POLL_MAX(POLLS)) u0 (.*);

    // engine model settings
    int         ready_after = 0;
    logic       err_m = 1'b0;
    logic [7:0] id_m = 8'h5A;
    logic [1:0] marker_m = 2'b01;
    int         pollcnt = 0;
    logic [15:0] cfg_m = '0;

    // transaction log: {rst, wr, addr, wdata}
    logic [28:0] tlog [0:4095];
    int          log_n = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            req_ack <= 1'b0;
        end else if (req_valid && !req_ack) begin
            req_ack <= 1'b1;
            tlog[log_n % 4096] <= {req_rst, req_wr, req_addr, req_wdata};
            log_n <= log_n + 1;
            if (req_rst) pollcnt <= 0;
            else if (req_wr) begin
                if (req_addr == 3'd2) cfg_m <= req_wdata[15:0];
                if (req_addr == 3'd1) pollcnt <= 0;
            end else begin
                case (req_addr)
                    3'd0: begin
                        req_rdata <= {16'h0, (pollcnt < ready_after), err_m, 1'b0,
                                      marker_m, cfg_m[2:0]};
                        pollcnt <= pollcnt + 1;
                    end
                    3'd3: req_rdata <= {cfg_m, 8'h3C};
                    3'd4: req_rdata <= {16'h0, id_m};
                    default: req_rdata <= '0;
                endcase
            end
        end else begin
            req_ack <= 1'b0;
        end
    end

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_cfg(input logic [2:0] g, input logic [3:0] c,
                                            input logic u, input logic [15:0] m);
        logic [15:0] w;
        w = m & ~16'h171F;
        w = w | (16'(u) << 12) | (16'(g) << 8) | 16'(c);
        if (g >= 3'd2 || m[4]) w = w | 16'h0010;
        return w;
    endfunction

    int base = 0;
    bit busy_bad = 0;

    task automatic run(input logic [1:0] op, input logic [3:0] c, input logic [2:0] g,
                       input logic u, input logic [15:0] m, input logic [12:0] mm);
        int n;
        @(negedge clk);
        base = log_n;
        cmd_op = op; cmd_chan = c; cmd_gain = g; cmd_unipolar = u;
        cmd_cfg_misc = m; cmd_mode_misc = mm; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_bad = 0;
        n = 0;
        while (!rsp_valid && n < 2000) begin
            if (cmd_ready) busy_bad = 1;
            @(negedge clk);
            n++;
        end
        if (n >= 2000) chk(0, "watchdog", 32'(n), 0);
    endtask

    function automatic logic [28:0] ent(input int k);
        return tlog[(base + k) % 4096];
    endfunction

    initial begin : wd
        wait (cyc > 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] ec;
        logic [15:0] misc;
        int polls;
        repeat (3) @(negedge clk);
        // R1
        chk(cmd_ready === 1'b1 && req_valid === 1'b0 && rsp_valid === 1'b0, "R1",
            {29'h0, cmd_ready, req_valid, rsp_valid}, 32'h4);
        rst_n = 1'b1;

        // R2 R3 R4 R11: sweep all gains and channels
        for (int g = 0; g < 8; g++) begin
            for (int c = 0; c < 16; c++) begin
                misc = ((g + c) % 2 == 0) ? 16'hE8E0 : 16'h2FF5;
                ready_after = (c % 3);
                ec = exp_cfg(3'(g), 4'(c), 1'(c >> 1), misc);
                run(2'd0, 4'(c), 3'(g), 1'(c >> 1), misc, 13'h0A5A);
                polls = ready_after + 1;
                chk(ent(0) == {1'b0, 1'b1, 3'd2, 8'h0, ec}, "R2/R3 cfg write",
                    32'(ent(0)), {3'b0, 1'b0, 1'b1, 3'd2, 8'h0, ec});
                chk(ent(1) == {1'b0, 1'b1, 3'd1, 8'h0, 3'b001, 13'h0A5A}, "R4 mode write",
                    32'(ent(1)), {3'b0, 2'b01, 3'd1, 8'h0, 3'b001, 13'h0A5A});
                chk(log_n - base == 3 + polls && ent(2 + polls)[28:24] == {2'b00, 3'd3},
                    "R4 poll count then data read", 32'(log_n - base), 32'(3 + polls));
                chk(rsp_data == {8'h00, ec, 8'h3C} && rsp_code == 2'd0, "R4 result",
                    rsp_data, {8'h00, ec, 8'h3C});
                chk(!busy_bad, "R11 cmd_ready low while busy", 32'(busy_bad), 0);
            end
        end

        // R11 pulse width
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 pulse", 32'(rsp_valid), 0);

        // R5 calibration
        ready_after = 2;
        run(2'd1, 4'd3, 3'd1, 1'b0, 16'h0000, 13'h0011);
        chk(log_n - base == 9, "R5 transaction count", 32'(log_n - base), 9);
        chk(ent(1)[15:0] == {3'b100, 13'h0011} && ent(5)[15:0] == {3'b101, 13'h0011}
            && ent(5)[27:24] == {1'b1, 3'd1}, "R5 zero then full scale",
            {ent(1)[15:0], ent(5)[15:0]}, {3'b100, 13'h0011, 3'b101, 13'h0011});
        chk(rsp_data == 32'h0 && rsp_code == 2'd0, "R5 result", rsp_data, 0);

        // R6 timeout in conversion
        ready_after = 100000;
        run(2'd0, 4'd1, 3'd0, 1'b0, 16'h0, 13'h0);
        chk(rsp_data == 32'hFFFF_FFFF && rsp_code == 2'd0, "R6 sentinel", rsp_data,
            32'hFFFF_FFFF);
        chk(log_n - base == 2 + POLLS, "R6 read count", 32'(log_n - base), 32'(2 + POLLS));
        // R6 timeout in calibration second pass is same counter; first pass here
        run(2'd1, 4'd1, 3'd0, 1'b0, 16'h0, 13'h0);
        chk(rsp_data == 32'hFFFF_FFFF && log_n - base == 2 + POLLS, "R6 calibration",
            rsp_data, 32'hFFFF_FFFF);

        // R7 error flag
        ready_after = 0; err_m = 1'b1;
        run(2'd0, 4'd2, 3'd0, 1'b0, 16'h0, 13'h0);
        chk(rsp_code == 2'd2 && rsp_data == 32'h0, "R7 error code", {rsp_code, rsp_data[29:0]},
            32'h8000_0000);
        chk(log_n - base == 3, "R7 no data read", 32'(log_n - base), 3);
        err_m = 1'b0;

        // R8 reset, absent device
        id_m = 8'h00;
        run(2'd2, 4'd0, 3'd0, 1'b0, 16'h0, 13'h0);
        chk(rsp_code == 2'd1 && rsp_data == 32'h0 && log_n - base == 2, "R8 id 00",
            32'(rsp_code), 1);
        chk(ent(0)[28] == 1'b1 && ent(1)[27:24] == {1'b0, 3'd4}, "R8 sequence",
            32'(ent(1)), 32'h0400_0000);
        id_m = 8'hFF;
        run(2'd2, 4'd0, 3'd0, 1'b0, 16'h0, 13'h0);
        chk(rsp_code == 2'd1 && rsp_data == 32'hFF, "R8 id FF", rsp_data, 32'hFF);

        // R9 marker
        id_m = 8'h5A; marker_m = 2'b01;
        run(2'd2, 4'd0, 3'd0, 1'b0, 16'h0, 13'h0);
        chk(rsp_code == 2'd0 && rsp_data == 32'h5A && log_n - base == 3, "R9 good marker",
            {rsp_code, rsp_data[29:0]}, 32'h5A);
        marker_m = 2'b11;
        run(2'd2, 4'd0, 3'd0, 1'b0, 16'h0, 13'h0);
        chk(rsp_code == 2'd2 && rsp_data == 32'h5A, "R9 bad marker", 32'(rsp_code), 2);
        marker_m = 2'b01;

        // R12 unused op
        run(2'd3, 4'd0, 3'd0, 1'b0, 16'h0, 13'h0);
        chk(rsp_code == 2'd2 && rsp_data == 32'h0 && log_n == base, "R12 unused op",
            32'(log_n - base), 0);

        // R10 request held stable while waiting is covered by req_hold_chk
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule